// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

A 32-bit combinational binary adder. It takes two operands and a carry-in, and it returns a 32-bit sum and a carry-out. The word is split into four 8-bit groups: bits 7..0, 15..8, 23..16 and 31..24. Inside each group, every bit forms a generate term (AND of the operand bits) and a propagate term (XOR of the operand bits). The group's internal carries are then formed as flat sums of products of those terms. Each group also reports a group generate and a group propagate.

By default, a second lookahead stage takes the four group generate/propagate pairs and the carry-in. From them it forms the carries at bits 8, 16 and 24 and the final carry at bit 32, each with two levels of logic. A build-time parameter swaps that stage for a plain chain, in which each group's carry-out feeds the next group. The result is the same in both forms; only the carry path depth changes.

The block is a drop-in arithmetic core for datapaths that need an unsigned add with a carry-in. It has no clock, no registers and no control inputs.

Top module: `cla_adder32`

## Requirements
- R1: `sum_o` equals the low 32 bits of `x_i + y_i + c_i`, taken as unsigned values.
- R2: `c_o` equals bit 32 of the 33-bit unsigned result `x_i + y_i + c_i`.
- R3: With `x_i` = 0xFFFFFFFF, `y_i` = 0 and `c_i` = 1, the carry passes through all four groups: `sum_o` = 0 and `c_o` = 1.
- R4: A carry generated at the top bit of one group is seen at the lowest bit of the next group. For example, 0x80 + 0x80 gives 0x100, and 0x00FFFFFF + 1 gives 0x01000000.
- R5: When every bit position propagates (operands are bitwise complements, for example 0xAAAAAAAA and 0x55555555), the result depends only on `c_i`: with `c_i` = 0 the result is `sum_o` = 0xFFFFFFFF and `c_o` = 0, and with `c_i` = 1 it is `sum_o` = 0 and `c_o` = 1.
- R6: With parameter `USE_L2` = 0 (group-to-group carry chain), the block gives the same `sum_o` and `c_o` as with `USE_L2` = 1 for every input.
- R7: With all inputs at zero, `sum_o` and `c_o` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | 32 | First operand |
| y_i | input | 32 | Second operand |
| c_i | input | 1 | Carry into bit 0 |
| sum_o | output | 32 | Sum bits |
| c_o | output | 1 | Carry out of bit 31 |

## Verification
A bad term inside a group, such as a wrong generate product or a missing propagate factor, shows on `sum_o` at once. It appears in the same evaluation, but only for operand patterns that drive a carry across the faulty term. For that reason the directed vectors force long propagate runs and group-edge generates. A fault in the second lookahead stage corrupts the lowest sum bit of the following group, or `c_o`, whenever a carry has to cross a group edge. Comparing the lookahead build with the chained build on the same inputs exposes any difference between the two carry paths directly.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned GRP_W  = 8;
  localparam int unsigned NUM_GRP = WORD_W / GRP_W;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [GRP_W-1:0]  grp_t;
endpackage

// File: rtl/cla_lookahead.sv
// Flat sum-of-products lookahead over N generate/propagate pairs.
module cla_lookahead #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] g_i,
  input  logic [N-1:0] p_i,
  input  logic         c_i,
  output logic [N:0]   carry_o,
  output logic         grp_g_o,
  output logic         grp_p_o
);

  always_comb begin
    carry_o[0] = c_i;
    for (int k = 0; k < N; k++) begin
      logic acc;
      logic run;
      acc = 1'b0;
      run = 1'b1;
      for (int m = k; m >= 0; m--) begin
        acc = acc | (run & g_i[m]);
        run = run & p_i[m];
      end
      carry_o[k+1] = acc | (run & c_i);
    end
  end

  always_comb begin
    logic acc;
    logic run;
    acc = 1'b0;
    run = 1'b1;
    for (int m = N - 1; m >= 0; m--) begin
      acc = acc | (run & g_i[m]);
      run = run & p_i[m];
    end
    grp_g_o = acc;
    grp_p_o = run;
  end

  always_comb begin
    for (int k = 0; k < N; k++) begin
      // R1
      carry_rec_chk: assert (carry_o[k+1] == (g_i[k] | (p_i[k] & carry_o[k])));
    end
    // R1
    grp_carry_chk: assert (carry_o[N] == (grp_g_o | (grp_p_o & c_i)));
  end

endmodule

// File: rtl/cla_group.sv
// One group: bit terms, internal lookahead, sum.
module cla_group #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         c_i,
  output logic [W-1:0] sum_o,
  output logic         c_o,
  output logic         grp_g_o,
  output logic         grp_p_o
);

  logic [W-1:0] g;
  logic [W-1:0] p;
  logic [W:0]   carry;

  assign g = x_i & y_i;
  assign p = x_i ^ y_i;

  cla_lookahead #(.N(W)) u_la (
    .g_i     (g),
    .p_i     (p),
    .c_i     (c_i),
    .carry_o (carry),
    .grp_g_o (grp_g_o),
    .grp_p_o (grp_p_o)
  );

  assign sum_o = p ^ carry[W-1:0];
  assign c_o   = carry[W];

  always_comb begin
    // R5
    grp_pg_excl_chk: assert (!(grp_p_o && grp_g_o));
    // R5
    grp_full_prop_chk: assert (!grp_p_o || (sum_o == {W{~c_i}}));
  end

endmodule

// File: rtl/cla_adder32.sv
module cla_adder32
  import cla_pkg::*;
#(
  parameter bit USE_L2 = 1'b1
) (
  input  logic [WORD_W-1:0] x_i,
  input  logic [WORD_W-1:0] y_i,
  input  logic              c_i,
  output logic [WORD_W-1:0] sum_o,
  output logic              c_o
);

  logic [NUM_GRP:0]   gc;
  logic [NUM_GRP-1:0] grp_g;
  logic [NUM_GRP-1:0] grp_p;
  logic [NUM_GRP-1:0] grp_co;

  assign gc[0] = c_i;

  for (genvar j = 0; j < NUM_GRP; j++) begin : g_grp
    cla_group #(.W(GRP_W)) u_grp (
      .x_i     (x_i[j*GRP_W +: GRP_W]),
      .y_i     (y_i[j*GRP_W +: GRP_W]),
      .c_i     (gc[j]),
      .sum_o   (sum_o[j*GRP_W +: GRP_W]),
      .c_o     (grp_co[j]),
      .grp_g_o (grp_g[j]),
      .grp_p_o (grp_p[j])
    );
  end

  if (USE_L2) begin : g_l2
    logic l2_g;
    logic l2_p;
    logic [NUM_GRP:0] l2_carry;

    cla_lookahead #(.N(NUM_GRP)) u_l2 (
      .g_i     (grp_g),
      .p_i     (grp_p),
      .c_i     (c_i),
      .carry_o (l2_carry),
      .grp_g_o (l2_g),
      .grp_p_o (l2_p)
    );

    assign gc[NUM_GRP:1] = l2_carry[NUM_GRP:1];

    always_comb begin
      for (int j = 0; j < NUM_GRP; j++) begin
        // R4
        l2_vs_grp_chk: assert (l2_carry[j+1] == grp_co[j]);
      end
      // R2
      l2_top_chk: assert (l2_carry[NUM_GRP] == (l2_g | (l2_p & c_i)));
    end
  end else begin : g_chain
    assign gc[NUM_GRP:1] = grp_co;
  end

  assign c_o = gc[NUM_GRP];

  always_comb begin
    // R2
    full_sum_chk: assert ({c_o, sum_o} == ({1'b0, x_i} + {1'b0, y_i} + {{WORD_W{1'b0}}, c_i}));
  end

endmodule

// File: tb/cla_adder32_tb.sv
module cla_adder32_tb;
  localparam int NV = 11;
  localparam int NRAND = 2000;

  // {x, y, cin, expected {cout,sum}}
  typedef struct packed {
    logic [31:0] x;
    logic [31:0] y;
    logic        c;
    logic [32:0] exp;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{32'h0000_0000, 32'h0000_0000, 1'b0, 33'h0_0000_0000},
    '{32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 33'h1_0000_0000},
    '{32'hFFFF_FFFF, 32'h0000_0000, 1'b1, 33'h1_0000_0000},
    '{32'hAAAA_AAAA, 32'h5555_5555, 1'b0, 33'h0_FFFF_FFFF},
    '{32'hAAAA_AAAA, 32'h5555_5555, 1'b1, 33'h1_0000_0000},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 33'h1_FFFF_FFFF},
    '{32'h0000_0080, 32'h0000_0080, 1'b0, 33'h0_0000_0100},
    '{32'h00FF_FFFF, 32'h0000_0001, 1'b0, 33'h0_0100_0000},
    '{32'h8000_0000, 32'h8000_0000, 1'b0, 33'h1_0000_0000},
    '{32'h1234_5678, 32'h9ABC_DEF0, 1'b0, 33'h0_ACF1_3568},
    '{32'h0000_FF00, 32'h0000_0100, 1'b0, 33'h0_0001_0000}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] x, y;
  logic        cin;
  logic [31:0] sum_l2, sum_ch;
  logic        co_l2, co_ch;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  cla_adder32 #(.USE_L2(1'b1)) u_dut (
    .x_i(x), .y_i(y), .c_i(cin), .sum_o(sum_l2), .c_o(co_l2)
  );

  cla_adder32 #(.USE_L2(1'b0)) u_dut_chain (
    .x_i(x), .y_i(y), .c_i(cin), .sum_o(sum_ch), .c_o(co_ch)
  );

  task automatic check(input string req, input logic [32:0] exp);
    n_run++;
    if ({co_l2, sum_l2} !== exp) begin
      n_fail++;
      $display("FAIL %s x=%h y=%h c=%b lookahead got=%h exp=%h", req, x, y, cin, {co_l2, sum_l2}, exp);
    end
    n_run++;
    if ({co_ch, sum_ch} !== exp) begin
      n_fail++;
      $display("FAIL R6 x=%h y=%h c=%b chain got=%h exp=%h", x, y, cin, {co_ch, sum_ch}, exp);
    end
  endtask

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic c);
    @(negedge clk);
    x = a; y = b; cin = c;
    #5;
  endtask

  initial begin
    x = '0; y = '0; cin = 1'b0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;

    // R7: zero inputs
    apply(32'h0, 32'h0, 1'b0);
    check("R7", 33'h0);

    // R1 R2 R3 R4 R5 directed table
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].x, VECS[i].y, VECS[i].c);
      check((i == 2) ? "R3" : (i == 3 || i == 4) ? "R5" :
            (i == 6 || i == 7 || i == 10) ? "R4" :
            (i == 1 || i == 8) ? "R2" : "R1", VECS[i].exp);
    end

    // R5: every bit propagates, carry comes only from cin
    for (int s = 0; s < 32; s++) begin
      logic [31:0] a;
      a = 32'h1 << s;
      a = a ^ 32'h3C3C_A5A5;
      apply(a, ~a, 1'b1);
      check("R5", 33'h1_0000_0000);
    end

    // R4: carry born at each group top crosses the edge
    for (int j = 0; j < 3; j++) begin
      logic [31:0] a;
      a = 32'h80 << (8 * j);
      apply(a, a, 1'b0);
      check("R4", {1'b0, a << 1});
    end

    // R1 R2 R6 random
    for (int i = 0; i < NRAND; i++) begin
      logic [31:0] a, b;
      logic c;
      a = $urandom;
      b = $urandom;
      c = 1'(($urandom >> 3) & 1);
      apply(a, b, c);
      check("R1", {1'b0, a} + {1'b0, b} + {32'h0, c});
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule